// File: doc/BRIEF.md
# Fault-Secure (15,7) Systematic Encoder

This block turns a 7-bit data word into a 15-bit codeword of a cyclic code with minimum distance 5. That code can be decoded in one step by majority logic. The codeword is systematic: the data appears unchanged in the upper bits, and 8 check bits fill the lower bits. The check bits come from the generator polynomial g(x) = 1 + x^4 + x^6 + x^7 + x^8.

A syndrome checker sits on the encoder's registered output. It recomputes the remainder of the codeword modulo g(x). If the syndrome is nonzero, the word is not released. Instead, the encode is run again from the held data. A bounded number of re-encodes is allowed. If the word is still bad after the last one, it is released with a hard-fail flag.

A fault-injection input XORs a mask onto the encoder output, on the first attempt only. This lets the retry path be exercised.

Top module: `ecc15_fs_encoder`

## Requirements
- R1: After reset, inReady is 1, outValid is 0 and hardFail is 0.
- R2: Codeword bits 14:8 equal the data word. Bits 7:0 hold the remainder of x^8·d(x) modulo g(x), where data bit i is the coefficient of x^i and codeword bit j is the coefficient of x^j. Example: data 7'h01 gives codeword 15'h01D1.
- R3: With a zero injection mask, outValid pulses for exactly one cycle, two clock edges after the accepting edge, with retryCount 0 and hardFail 0.
- R4: inReady is 1 only while idle. Data offered while the block is busy is ignored: it neither changes the codeword in flight nor produces an extra output.
- R5: A mask that makes the word fail the syndrome check causes one re-encode without the mask. The correct codeword is then released four edges after acceptance, with retryCount 1 and hardFail 0.
- R6: A mask equal to a valid codeword escapes the checker. The released word is the correct codeword XOR the mask, with retryCount 0.
- R7: When retries reach MAX_RETRY and the syndrome is still nonzero, the word is released as it stands, with hardFail 1. With MAX_RETRY = 0, an injected error is released at the normal latency with hardFail 1 and retryCount 0.
- R8: Whenever outValid is 1 and hardFail is 0, the released codeword has a zero syndrome, and retryCount never exceeds MAX_RETRY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Data offer |
| inReady | output | 1 | Block idle, accepts data |
| inData | input | 7 | Data word |
| injectMask | input | 15 | XOR mask applied to the first encode attempt |
| outValid | output | 1 | One-cycle codeword strobe |
| outCodeword | output | 15 | Released codeword |
| retryCount | output | $clog2(MAX_RETRY+2) | Re-encodes used for this word |
| hardFail | output | 1 | Released word still fails the syndrome check |

## Verification
The encode path is driven with the all-zero, all-one, single-bit and alternating data words. These separate a wrong bit order from a wrong polynomial tap. Masks of weight 1 on a data bit, weight 1 on a check bit and weight 4 show that every pattern under the code distance forces exactly one re-encode. A mask equal to a codeword shows the one class of pattern the checker cannot see. A second instance with no retries allowed shows that the hard-fail flag is raised together with the corrupted word. Offers made while busy show that the held data is protected.

// File: rtl/ecc15_pkg.sv
package ecc15_pkg;
  localparam int DATA_W = 7;
  localparam int CODE_W = 15;
  localparam int PAR_W  = CODE_W - DATA_W;
  // generator 1 + x^4 + x^6 + x^7 + x^8
  localparam logic [PAR_W:0] GEN_POLY = 9'h1D1;

  typedef struct packed {
    logic load;
    logic encode;
    logic firstTry;
  } ctlStrobe_t;

  // remainder modulo GEN_POLY; doubles as parity-check (syndrome) function
  function automatic logic [PAR_W-1:0] polyRem(input logic [CODE_W-1:0] v);
    logic [CODE_W-1:0] r;
    r = v;
    for (int i = CODE_W - 1; i >= PAR_W; i--) begin
      if (r[i]) r = r ^ ({{(CODE_W-PAR_W-1){1'b0}}, GEN_POLY} << (i - PAR_W));
    end
    return r[PAR_W-1:0];
  endfunction

  function automatic logic [CODE_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    return {d, polyRem({d, {PAR_W{1'b0}}})};
  endfunction
endpackage

// File: rtl/ecc15_datapath.sv
module ecc15_datapath
  import ecc15_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic [CODE_W-1:0] injectMask,
  output logic [CODE_W-1:0] outCodeword,
  output logic              synZero
);
  logic [DATA_W-1:0] dataReg;
  logic [CODE_W-1:0] cwReg;
  logic [PAR_W-1:0]  syndrome;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      cwReg   <= '0;
    end else begin
      if (ctl.load) dataReg <= inData;
      if (ctl.encode) cwReg <= encodeWord(dataReg) ^ (ctl.firstTry ? injectMask : '0);
    end
  end

  always_comb begin
    syndrome    = polyRem(cwReg);
    synZero     = (syndrome == '0);
    outCodeword = cwReg;
  end

  // R2: a clean (unmasked) encode always leaves a word with zero syndrome
  assert_clean_encode_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.encode && !ctl.firstTry) |=> synZero);
endmodule

// File: rtl/ecc15_control.sv
module ecc15_control
  import ecc15_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  localparam int RETRY_W = $clog2(MAX_RETRY + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               synZero,
  output logic               inReady,
  output ctlStrobe_t         ctl,
  output logic               outValid,
  output logic               hardFail,
  output logic [RETRY_W-1:0] retryCount
);
  typedef enum logic [1:0] {ST_IDLE, ST_ENC, ST_CHK} state_t;
  state_t state;
  logic [RETRY_W-1:0] retries;
  logic atLimit;

  always_comb begin
    atLimit      = (retries == RETRY_W'(MAX_RETRY));
    inReady      = (state == ST_IDLE);
    ctl.load     = (state == ST_IDLE) && inValid;
    ctl.encode   = (state == ST_ENC);
    ctl.firstTry = (retries == '0);
    outValid     = (state == ST_CHK) && (synZero || atLimit);
    hardFail     = (state == ST_CHK) && !synZero && atLimit;
    retryCount   = retries;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      retries <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (inValid) begin
          state   <= ST_ENC;
          retries <= '0;
        end
        ST_ENC: state <= ST_CHK;
        ST_CHK: if (outValid) state <= ST_IDLE;
                else begin
                  state   <= ST_ENC;
                  retries <= retries + 1'b1;
                end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  assert_retry_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    retryCount <= RETRY_W'(MAX_RETRY));
  assert_fail_with_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    hardFail |-> (outValid && retryCount == RETRY_W'(MAX_RETRY)));
endmodule

// File: rtl/ecc15_fs_encoder.sv
module ecc15_fs_encoder
  import ecc15_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  localparam int RETRY_W = $clog2(MAX_RETRY + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [DATA_W-1:0]  inData,
  input  logic [CODE_W-1:0]  injectMask,
  output logic               outValid,
  output logic [CODE_W-1:0]  outCodeword,
  output logic [RETRY_W-1:0] retryCount,
  output logic               hardFail
);
  ctlStrobe_t ctl;
  logic synZero;

  ecc15_control #(.MAX_RETRY(MAX_RETRY)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .synZero(synZero),
    .inReady(inReady), .ctl(ctl), .outValid(outValid),
    .hardFail(hardFail), .retryCount(retryCount)
  );

  ecc15_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .injectMask(injectMask), .outCodeword(outCodeword), .synZero(synZero)
  );

  assert_released_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !hardFail) |-> (polyRem(outCodeword) == '0));
  assert_ready_low_on_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);
endmodule

// File: tb/tb_ecc15_fs_encoder.sv
`timescale 1ns/1ps
module tb_ecc15_fs_encoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [6:0] inData = '0;
  logic [14:0] injectMask = '0;
  logic inReady, outValid, hardFail;
  logic [14:0] outCodeword;
  logic [2:0] retryCount;
  logic nrReady, nrValid, nrFail;
  logic [14:0] nrCode;
  logic [0:0] nrRetry;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ecc15_fs_encoder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .injectMask(injectMask), .outValid(outValid), .outCodeword(outCodeword),
    .retryCount(retryCount), .hardFail(hardFail));

  ecc15_fs_encoder #(.MAX_RETRY(0)) dutNoRetry (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(nrReady), .inData(inData),
    .injectMask(injectMask), .outValid(nrValid), .outCodeword(nrCode),
    .retryCount(nrRetry), .hardFail(nrFail));

  // expected systematic codeword: search the multiple m(x)*g(x) whose top bits equal d
  function automatic logic [14:0] expCode(input logic [6:0] d);
    logic [14:0] p;
    for (int m = 0; m < 128; m++) begin
      p = '0;
      for (int i = 0; i < 7; i++)
        if (m[i]) p = p ^ (15'h01D1 << i);
      if (p[14:8] == d) return p;
    end
    return '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // send one word, return latency (edges after accept) and captured outputs
  int lat, nrLat;
  logic [14:0] capCode, nrCapCode;
  logic [2:0] capRetry;
  logic capFail, nrCapFail;
  logic [0:0] nrCapRetry;

  task automatic sendWord(input logic [6:0] d, input logic [14:0] mask);
    @(negedge clk);
    inValid = 1'b1; inData = d; injectMask = mask;
    @(negedge clk);
    inValid = 1'b0;
    lat = 1; nrLat = 0;
    while (!outValid && lat < 20) begin
      if (nrValid && nrLat == 0) begin
        nrLat = lat; nrCapCode = nrCode; nrCapFail = nrFail; nrCapRetry = nrRetry;
      end
      @(negedge clk);
      lat++;
    end
    if (nrValid && nrLat == 0) begin
      nrLat = lat; nrCapCode = nrCode; nrCapFail = nrFail; nrCapRetry = nrRetry;
    end
    capCode = outCodeword; capRetry = retryCount; capFail = hardFail;
    @(negedge clk);
    chk(!outValid, "R3 single-cycle strobe", outValid, 0);
    chk(inReady, "R4 ready back when idle", inReady, 1);
    injectMask = '0;
  endtask

  task automatic testReset();
    chk(inReady == 1'b1, "R1 inReady", inReady, 1);
    chk(outValid == 1'b0, "R1 outValid", outValid, 0);
    chk(hardFail == 1'b0, "R1 hardFail", hardFail, 0);
  endtask

  task automatic testKnownWord();
    sendWord(7'h01, '0);
    chk(capCode == 15'h01D1, "R2 data 01 codeword", capCode, 15'h01D1);
  endtask

  task automatic testClean(input logic [6:0] d);
    sendWord(d, '0);
    chk(capCode == expCode(d), "R2 codeword", capCode, expCode(d));
    chk(lat == 2, "R3 latency", lat, 2);
    chk(capRetry == 0 && !capFail, "R3 no retry", {capRetry, capFail}, 0);
  endtask

  task automatic testRetry(input logic [6:0] d, input logic [14:0] mask);
    sendWord(d, mask);
    chk(capCode == expCode(d), "R5 corrected codeword", capCode, expCode(d));
    chk(lat == 4, "R5 retry latency", lat, 4);
    chk(capRetry == 1 && !capFail, "R5 retry count", {capRetry, capFail}, 4'b0010);
    chk(nrLat == 2 && nrCapFail, "R7 hard fail no-retry", {nrLat[3:0], nrCapFail}, 5'b00101);
    chk(nrCapCode == (expCode(d) ^ mask), "R7 corrupted word", nrCapCode, expCode(d) ^ mask);
    chk(nrCapRetry == 0, "R7 retry count", nrCapRetry, 0);
  endtask

  task automatic testEscape();
    sendWord(7'h05, 15'h01D1);
    chk(capCode == (expCode(7'h05) ^ 15'h01D1), "R6 undetected mask", capCode, expCode(7'h05) ^ 15'h01D1);
    chk(capRetry == 0 && !capFail && lat == 2, "R6 no retry", {lat[3:0], capRetry, capFail}, 8'h20);
  endtask

  task automatic testBusyIgnore();
    int seen;
    @(negedge clk);
    inValid = 1'b1; inData = 7'h33; injectMask = '0;
    @(negedge clk);
    chk(!inReady, "R4 busy ready low", inReady, 0);
    inData = 7'h4C;
    @(negedge clk);
    chk(outValid && outCodeword == expCode(7'h33), "R4 held data kept", outCodeword, expCode(7'h33));
    inValid = 1'b0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (outValid) seen++;
    end
    chk(seen == 0, "R4 no extra output", seen, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testKnownWord();
    testClean(7'h00);
    testClean(7'h7F);
    testClean(7'h2A);
    testClean(7'h40);
    testRetry(7'h2A, 15'h4000);
    testRetry(7'h11, 15'h0001);
    testRetry(7'h6B, 15'h0F00);
    testEscape();
    testBusyIgnore();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule